// File: doc/BRIEF.md
# SDRAM Bank Precharge and Power-Down Tracker

This block sits beside an SDRAM command bus and follows it one command per clock. For every bank it records whether a row is open, and after a precharge it counts down the recovery time before that bank may be activated again. It reports three protocol errors: a read or write to a bank with no open row, an activate that comes too early or targets an already open bank, and any real command issued while the device is powered down.

The block also follows the clock-enable line. A NOP or deselect with the clock enable low, while no bank is still in precharge recovery, puts the tracked device into power-down. The power-down flavour is fixed at entry from the live bank state: precharge power-down when every bank is idle, active power-down when any row is open. A cycle counter limits how long power-down may last, because the device does no refresh in that state. A NOP or deselect with the clock enable high ends power-down.

Top module: `sdram_bank_pd_tracker`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: cs_n=1 is a deselect; 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE; any other code has no effect on bank or power state. An accepted ACTIVE to a ready bank sets its bit in bank_open after the clock edge.
- R2: A READ or WRITE outside power-down to a bank whose bank_open bit is 0 makes err_idle_access high for exactly the one cycle after that edge.
- R3: PRECHARGE with pre_all=0 closes only the bank named by bank_sel. PRECHARGE with pre_all=1 closes every bank, whatever bank_sel holds. A PRECHARGE to a bank that is already idle leaves it idle and does not restart its recovery time.
- R4: After a PRECHARGE closes a bank at edge p, an ACTIVE to it is accepted at edge p+T_RP or later. An ACTIVE at an earlier edge, or to an open bank, leaves bank_open unchanged and makes err_act_reject high for one cycle. bank_ready shows the banks that are idle and past recovery.
- R5: Outside power-down, a NOP or deselect sampled with cke=0 while no bank is in recovery enters power-down at that edge. With a bank in recovery, or with any other command, cke=0 causes no entry and the command is handled normally.
- R6: On entry pd_precharge goes high if all banks are idle and pd_active goes high if any bank is open; at most one of them is high.
- R7: In power-down, a NOP or deselect sampled with cke=1 leaves power-down at that edge: pd_precharge, pd_active and pd_overflow are 0 afterwards.
- R8: In power-down, any command other than NOP or deselect is ignored (bank_open unchanged, power-down kept) and makes err_pd_cmd high for one cycle.
- R9: pd_overflow goes high after the power-down has lasted more than PD_LIMIT edges following the entry edge (at entry edge + PD_LIMIT + 1). It stays high until exit or reset.
- R10: While rst is high, every bank is idle and ready, power-down is left, and all error and overflow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as sampled by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| pre_all | input | 1 | All-bank select during PRECHARGE |
| bank_sel | input | BANK_W | Bank address of the command |
| bank_open | output | NUM_BANKS | One bit per bank with an open row |
| bank_ready | output | NUM_BANKS | Bank idle and past its precharge recovery |
| pd_precharge | output | 1 | In power-down with all banks idle |
| pd_active | output | 1 | In power-down with a row open |
| pd_overflow | output | 1 | Power-down lasted past the refresh limit |
| err_idle_access | output | 1 | Read or write to an idle bank |
| err_act_reject | output | 1 | ACTIVE to an open or recovering bank |
| err_pd_cmd | output | 1 | Non-NOP command during power-down |

## Verification
The bench builds the block with T_RP=3 and PD_LIMIT=20, with four banks. Three recovery cycles are enough to show an ACTIVE rejected one edge before the limit and accepted on it, and to show power-down entry held back by a bank still in recovery. A limit of twenty edges lets the bench walk across the overflow boundary a cycle at a time, which the 64 ms default would put far out of reach.

// File: rtl/sdpd_pkg.sv
package sdpd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_READ,
        CMD_WRITE,
        CMD_PRE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN,
        PWR_PD_PRE,
        PWR_PD_ACT
    } pwr_e;

    typedef struct packed {
        logic idle_access;
        logic act_reject;
        logic pd_cmd;
    } err_t;

    // Deselect counts as a NOP for every purpose of this block.
    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_PRE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_rw(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sdpd_cmd_decode.sv
module sdpd_cmd_decode
    import sdpd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 pre_all,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 accept,
    output logic                 idle_cmd,
    output logic [NUM_BANKS-1:0] act_req,
    output logic [NUM_BANKS-1:0] pre_req,
    output logic [NUM_BANKS-1:0] rw_req
);

    cmd_e cmd;

    assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign idle_cmd = (cmd == CMD_NOP);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit        = (bank_sel == BANK_W'(i));
        assign act_req[i] = accept && (cmd == CMD_ACT) && hit;
        assign rw_req[i]  = accept && is_rw(cmd) && hit;
        assign pre_req[i] = accept && (cmd == CMD_PRE) && (pre_all || hit);
    end

endmodule

// File: rtl/sdpd_bank_slot.sv
module sdpd_bank_slot #(
    parameter int T_RP = 3,
    localparam int TRP_W = (T_RP < 2) ? 1 : $clog2(T_RP)
) (
    input  logic clk,
    input  logic rst,
    input  logic act_req,
    input  logic pre_req,
    input  logic rw_req,
    output logic is_open,
    output logic is_ready,
    output logic is_busy,
    output logic act_err,
    output logic rw_err
);

    localparam logic [TRP_W-1:0] LOAD_C = TRP_W'(T_RP - 1);

    logic [TRP_W-1:0] timer;

    assign is_busy  = (timer != '0);
    assign is_ready = !is_open && !is_busy;
    assign act_err  = act_req && !is_ready;
    assign rw_err   = rw_req && !is_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            timer   <= '0;
        end else if (pre_req && is_open) begin
            is_open <= 1'b0;
            timer   <= LOAD_C;
        end else if (act_req && is_ready) begin
            is_open <= 1'b1;
        end else if (is_busy) begin
            timer <= timer - 1'b1;
        end
    end

endmodule

// File: rtl/sdpd_power_ctrl.sv
module sdpd_power_ctrl
    import sdpd_pkg::*;
#(
    parameter int PD_LIMIT = 6400000,
    localparam int CNT_W = $clog2(PD_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic idle_cmd,
    input  logic any_open,
    input  logic any_busy,
    output pwr_e state,
    output logic overflow,
    output logic err_cmd
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(PD_LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PWR_RUN;
            cnt      <= '0;
            overflow <= 1'b0;
            err_cmd  <= 1'b0;
        end else begin
            err_cmd <= 1'b0;
            if (state == PWR_RUN) begin
                cnt      <= '0;
                overflow <= 1'b0;
                if (!cke && idle_cmd && !any_busy) begin
                    state <= any_open ? PWR_PD_ACT : PWR_PD_PRE;
                end
            end else if (idle_cmd && cke) begin
                state    <= PWR_RUN;
                cnt      <= '0;
                overflow <= 1'b0;
            end else begin
                err_cmd <= !idle_cmd;
                if (cnt == LIMIT_C) begin
                    overflow <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdram_bank_pd_tracker.sv
module sdram_bank_pd_tracker
    import sdpd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int PD_LIMIT  = 6400000,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 pre_all,
    input  logic [BANK_W-1:0]    bank_sel,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 pd_precharge,
    output logic                 pd_active,
    output logic                 pd_overflow,
    output logic                 err_idle_access,
    output logic                 err_act_reject,
    output logic                 err_pd_cmd
);

    logic                 accept;
    logic                 idle_cmd;
    logic [NUM_BANKS-1:0] act_req, pre_req, rw_req;
    logic [NUM_BANKS-1:0] busy, act_err, rw_err;
    pwr_e                 pwr_state;
    err_t                 err_q;
    logic                 pd_err;

    assign accept = (pwr_state == PWR_RUN);

    sdpd_cmd_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .pre_all  (pre_all),
        .bank_sel (bank_sel),
        .accept   (accept),
        .idle_cmd (idle_cmd),
        .act_req  (act_req),
        .pre_req  (pre_req),
        .rw_req   (rw_req)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
        sdpd_bank_slot #(.T_RP(T_RP)) i_slot (
            .clk      (clk),
            .rst      (rst),
            .act_req  (act_req[i]),
            .pre_req  (pre_req[i]),
            .rw_req   (rw_req[i]),
            .is_open  (bank_open[i]),
            .is_ready (bank_ready[i]),
            .is_busy  (busy[i]),
            .act_err  (act_err[i]),
            .rw_err   (rw_err[i])
        );
    end

    sdpd_power_ctrl #(.PD_LIMIT(PD_LIMIT)) i_power (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .idle_cmd (idle_cmd),
        .any_open (|bank_open),
        .any_busy (|busy),
        .state    (pwr_state),
        .overflow (pd_overflow),
        .err_cmd  (pd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.idle_access <= |rw_err;
            err_q.act_reject  <= |act_err;
            err_q.pd_cmd      <= 1'b0;
        end
    end

    assign pd_precharge    = (pwr_state == PWR_PD_PRE);
    assign pd_active       = (pwr_state == PWR_PD_ACT);
    assign err_idle_access = err_q.idle_access;
    assign err_act_reject  = err_q.act_reject;
    assign err_pd_cmd      = pd_err | err_q.pd_cmd;

endmodule

// File: rtl/sdpd_tracker_chk.sv
module sdpd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 pre_all,
    input logic [BANK_W-1:0]    bank_sel,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 pd_precharge,
    input logic                 pd_active,
    input logic                 pd_overflow,
    input logic                 err_idle_access,
    input logic                 err_act_reject,
    input logic                 err_pd_cmd
);

    logic in_pd, nop_like, is_act, is_rw, is_pre;

    assign in_pd    = pd_precharge | pd_active;
    assign nop_like = cs_n || ({ras_n, cas_n, we_n} == 3'b111);
    assign is_act   = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
    assign is_rw    = !cs_n && ras_n && !cas_n;
    assign is_pre   = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);

    // R6: never both power-down flavours at once
    a_r6_pd_flavour: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pd_precharge, pd_active}));

    // R2: access to an idle bank is reported on the next cycle
    a_r2_idle_access: assert property (@(posedge clk) disable iff (rst)
        (!in_pd && is_rw && !bank_open[bank_sel]) |=> err_idle_access);

    // R4: activate to an open bank is refused
    a_r4_act_open: assert property (@(posedge clk) disable iff (rst)
        (!in_pd && is_act && bank_open[bank_sel]) |=> err_act_reject);

    // R4: an open bank is never reported ready
    a_r4_ready_idle: assert property (@(posedge clk) disable iff (rst)
        (bank_ready & bank_open) == '0);

    // R3: all-bank precharge closes everything
    a_r3_pre_all: assert property (@(posedge clk) disable iff (rst)
        (!in_pd && is_pre && pre_all) |=> (bank_open == '0));

    // R8: bank state frozen while powered down
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        in_pd |=> $stable(bank_open));

    // R8: command error only arises from power-down
    a_r8_err_src: assert property (@(posedge clk) disable iff (rst)
        $rose(err_pd_cmd) |-> $past(in_pd));

    // R7: exit on NOP with clock enable high
    a_r7_exit: assert property (@(posedge clk) disable iff (rst)
        (in_pd && cke && nop_like) |=> !(pd_precharge || pd_active));

    // R9: overflow only exists inside power-down
    a_r9_ovf_in_pd: assert property (@(posedge clk) disable iff (rst)
        pd_overflow |-> in_pd);

endmodule

bind sdram_bank_pd_tracker sdpd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .cke             (cke),
    .cs_n            (cs_n),
    .ras_n           (ras_n),
    .cas_n           (cas_n),
    .we_n            (we_n),
    .pre_all         (pre_all),
    .bank_sel        (bank_sel),
    .bank_open       (bank_open),
    .bank_ready      (bank_ready),
    .pd_precharge    (pd_precharge),
    .pd_active       (pd_active),
    .pd_overflow     (pd_overflow),
    .err_idle_access (err_idle_access),
    .err_act_reject  (err_act_reject),
    .err_pd_cmd      (err_pd_cmd)
);

// File: tb/test_sdram_bank_pd_tracker.sv
module test_sdram_bank_pd_tracker;

    localparam int CLK_P    = 10;
    localparam int NB       = 4;
    localparam int TRP      = 3;
    localparam int LIMIT    = 20;
    localparam int NVEC     = 24;

    // Bench command codes: 0 NOP, 1 deselect, 2 ACTIVE, 3 READ, 4 WRITE,
    // 5 PRECHARGE, 6 other (refresh code)
    // Row: {cke, code[2:0], pre_all, bank[1:0], open[3:0], err{idle,act,pd}, pd{pre,act}}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b1, 3'd0, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd0, 4'b0001, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd2, 4'b0101, 3'b000, 2'b00},
        {1'b1, 3'd3, 1'b0, 2'd1, 4'b0101, 3'b100, 2'b00},
        {1'b1, 3'd4, 1'b0, 2'd2, 4'b0101, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd0, 4'b0101, 3'b010, 2'b00},
        {1'b1, 3'd5, 1'b0, 2'd0, 4'b0100, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd0, 4'b0100, 3'b010, 2'b00},
        {1'b1, 3'd0, 1'b0, 2'd0, 4'b0100, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd0, 4'b0101, 3'b000, 2'b00},
        {1'b1, 3'd5, 1'b1, 2'd3, 4'b0000, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd1, 4'b0010, 3'b000, 2'b00},
        {1'b1, 3'd2, 1'b0, 2'd2, 4'b0010, 3'b010, 2'b00},
        {1'b0, 3'd0, 1'b0, 2'd0, 4'b0010, 3'b000, 2'b01},
        {1'b0, 3'd2, 1'b0, 2'd0, 4'b0010, 3'b001, 2'b01},
        {1'b1, 3'd0, 1'b0, 2'd0, 4'b0010, 3'b000, 2'b00},
        {1'b1, 3'd5, 1'b0, 2'd1, 4'b0000, 3'b000, 2'b00},
        {1'b0, 3'd0, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b00},
        {1'b0, 3'd0, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b00},
        {1'b0, 3'd0, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b10},
        {1'b1, 3'd1, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b00},
        {1'b1, 3'd6, 1'b0, 2'd0, 4'b0000, 3'b000, 2'b00},
        {1'b1, 3'd3, 1'b0, 2'd3, 4'b0000, 3'b100, 2'b00},
        {1'b0, 3'd2, 1'b0, 2'd3, 4'b1000, 3'b000, 2'b00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          pre_all = 1'b0;
    logic [1:0]    bank_sel = '0;
    logic [NB-1:0] bank_open, bank_ready;
    logic          pd_precharge, pd_active, pd_overflow;
    logic          err_idle_access, err_act_reject, err_pd_cmd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sdram_bank_pd_tracker #(.NUM_BANKS(NB), .T_RP(TRP), .PD_LIMIT(LIMIT)) i_sdram_bank_pd_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .pre_all(pre_all), .bank_sel(bank_sel),
        .bank_open(bank_open), .bank_ready(bank_ready),
        .pd_precharge(pd_precharge), .pd_active(pd_active), .pd_overflow(pd_overflow),
        .err_idle_access(err_idle_access), .err_act_reject(err_act_reject),
        .err_pd_cmd(err_pd_cmd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic k, input logic [2:0] code, input logic a10,
                         input logic [1:0] b);
        cke      = k;
        pre_all  = a10;
        bank_sel = b;
        case (code)
            3'd0:    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            3'd1:    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            3'd2:    {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            3'd3:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            3'd4:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            3'd5:    {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 bank_open", 32'(bank_open), 32'h0);
        check("R10 bank_ready", 32'(bank_ready), 32'hF);
        check("R10 pd flags", 32'({pd_precharge, pd_active, pd_overflow}), 32'h0);
        check("R10 errors", 32'({err_idle_access, err_act_reject, err_pd_cmd}), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            drive(v[15], v[14:12], v[11], v[10:9]);
            check($sformatf("R1 R3 row %0d bank_open", i), 32'(bank_open), 32'(v[8:5]));
            check($sformatf("R2 row %0d err_idle_access", i), 32'(err_idle_access), 32'(v[4]));
            check($sformatf("R4 row %0d err_act_reject", i), 32'(err_act_reject), 32'(v[3]));
            check($sformatf("R8 row %0d err_pd_cmd", i), 32'(err_pd_cmd), 32'(v[2]));
            check($sformatf("R5 R6 R7 row %0d pd", i), 32'({pd_precharge, pd_active}), 32'(v[1:0]));
        end

        // R4: bank_ready reflects open bank 3 and idle others
        check("R4 bank_ready", 32'(bank_ready), 32'h7);

        // R9: overflow boundary in active power-down
        drive(1'b0, 3'd0, 1'b0, 2'd0);
        check("R6 active entry", 32'({pd_precharge, pd_active}), 32'h1);
        for (int k = 0; k < LIMIT; k++) drive(1'b0, 3'd1, 1'b0, 2'd0);
        check("R9 no overflow at limit", 32'(pd_overflow), 32'h0);
        drive(1'b0, 3'd0, 1'b0, 2'd0);
        check("R9 overflow past limit", 32'(pd_overflow), 32'h1);
        drive(1'b0, 3'd0, 1'b0, 2'd0);
        check("R9 overflow held", 32'(pd_overflow), 32'h1);
        drive(1'b1, 3'd0, 1'b0, 2'd0);
        check("R7 exit clears overflow", 32'({pd_precharge, pd_active, pd_overflow}), 32'h0);

        // R8: command with cke high inside power-down does not exit
        drive(1'b0, 3'd0, 1'b0, 2'd0);
        drive(1'b1, 3'd5, 1'b1, 2'd0);
        check("R8 pd kept", 32'(pd_active), 32'h1);
        check("R8 precharge ignored", 32'(bank_open), 32'h8);
        check("R8 err flagged", 32'(err_pd_cmd), 32'h1);

        // R10: reset in the middle of power-down
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10 reset leaves pd", 32'({pd_precharge, pd_active, pd_overflow}), 32'h0);
        check("R10 reset closes banks", 32'(bank_open), 32'h0);
        rst = 1'b0;

        // R3: precharge to idle bank does not start recovery
        drive(1'b1, 3'd5, 1'b0, 2'd2);
        drive(1'b1, 3'd2, 1'b0, 2'd2);
        check("R3 idle precharge no delay", 32'(bank_open), 32'h4);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule